// File: doc/BRIEF.md
# Mode-Control Register Write Unit

This block owns the processor's main mode-control register and every side effect of writing it. A write is accepted in one cycle. One clock later the stored value, the hidden mode flags derived from it and any one-cycle pulses are visible at the outputs. The pulses are a translation-cache flush request and a request to cut the program counter down to 32 bits.

The unit also runs the long-mode handshake. Turning paging on while the long-mode enable input is high switches long mode on, but only when the page-address-extension input is also high. Without that extension the write is dropped. Turning paging off while long mode is active leaves long mode. It also clears the 64-bit code flag and asks for program counter truncation. The 64-bit code flag itself is set from outside by a load strobe, and that strobe is honoured only while long mode is active.

Top module: `mcr_write_top`

## Requirements
- R1: While reset is asserted, and until the first accepted write, the outputs hold these values: stored register 0x00000010, and every flag and pulse 0.
- R2: An accepted write stores the written data with bit 4 forced to 1. The new value is visible on the clock edge after the write strobe.
- R3: The flush pulse is high for exactly the one cycle after a write whose data differs from the old stored value in bit 31, bit 16 or bit 0. A write that changes only other bits gives no pulse.
- R4: Long mode becomes active when a write takes bit 31 from 0 to 1 while the long-mode enable and the page-extension inputs are both high.
- R5: A write takes bit 31 from 0 to 1 while long-mode enable is high and the page-extension input is low. That write leaves the stored register, long mode and all hidden flags unchanged. Its flush pulse (R3) is still issued.
- R6: A write takes bit 31 from 1 to 0 while long mode is active. It clears long mode and the 64-bit code flag, and the truncate-PC pulse is high for one cycle. No other write raises that pulse.
- R7: The protected-mode flag follows bit 0 of each accepted write. The add-segment flag becomes 1 on any accepted write with bit 0 clear, and only reset clears it again.
- R8: The three FPU trap flags take bits 1, 2 and 3 of each accepted write, in that order: monitor, emulate, task-switched.
- R9: The 64-bit code flag is set by the load strobe only while long mode is active. It is never 1 while long mode is inactive.
- R10: With the write strobe low, the stored register and long mode keep their values, and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Value to write |
| addrExtEn | input | 1 | Page-address-extension enable |
| lmEnable | input | 1 | Long-mode enable |
| code64Load | input | 1 | Request to set the 64-bit code flag |
| ctlReg | output | 32 | Stored register value |
| longActive | output | 1 | Long mode active |
| codeWide64 | output | 1 | 64-bit code flag |
| truncPcPulse | output | 1 | Truncate program counter to 32 bits |
| flushPulse | output | 1 | Translation-cache flush request |
| protMode | output | 1 | Protected-mode hidden flag |
| addSegFlag | output | 1 | Add-segment hidden flag |
| fpuMonitor | output | 1 | FPU monitor trap flag |
| fpuEmulate | output | 1 | FPU emulate trap flag |
| fpuTaskSw | output | 1 | FPU task-switched trap flag |

## Verification
The write patterns each toggle a single one of the three flush bits, then change only non-flush bits, to separate a correct flush mask from a mask that is too wide or too narrow. Paging is turned on with long-mode enable and the extension input both low and high, and also with long-mode enable low. This separates a dropped write from a normal one and from a long-mode entry. Paging is turned off both inside and outside long mode, so a truncation pulse that fires too often is caught. The code-flag load strobe is applied both inside and outside long mode.

// File: rtl/mcr_write_pkg.sv
package mcr_write_pkg;
  localparam int unsigned CTL_W  = 32;
  localparam int unsigned PG_POS = 31;
  localparam int unsigned WP_POS = 16;
  localparam int unsigned PE_POS = 0;
  localparam int unsigned MP_POS = 1;
  localparam int unsigned ET_POS = 4;
  localparam int unsigned FPU_N  = 3;

  localparam logic [CTL_W-1:0] FLUSH_MASK =
    (CTL_W'(1) << PG_POS) | (CTL_W'(1) << WP_POS) | (CTL_W'(1) << PE_POS);
  localparam logic [CTL_W-1:0] FORCE_ONE = CTL_W'(1) << ET_POS;
  localparam logic [CTL_W-1:0] RESET_VAL = FORCE_ONE;

  typedef struct packed {
    logic flush;
    logic commit;
    logic enterLm;
    logic exitLm;
  } wrStrobe_t;
endpackage

// File: rtl/mcr_write_ctrl.sv
module mcr_write_ctrl
  import mcr_write_pkg::*;
(
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic             addrExtEn,
  input  logic             lmEnable,
  input  logic [CTL_W-1:0] curReg,
  input  logic             curLong,
  output wrStrobe_t        strobe
);
  logic pgRise;
  logic pgFall;
  logic enterTry;
  logic abandon;

  always_comb begin
    pgRise   = !curReg[PG_POS] && wrData[PG_POS];
    pgFall   = curReg[PG_POS] && !wrData[PG_POS];
    enterTry = wrEn && pgRise && lmEnable;
    abandon  = enterTry && !addrExtEn;

    strobe.flush   = wrEn && (|((wrData ^ curReg) & FLUSH_MASK));
    strobe.commit  = wrEn && !abandon;
    strobe.enterLm = enterTry && addrExtEn;
    strobe.exitLm  = wrEn && pgFall && curLong;
  end
endmodule

// File: rtl/mcr_write_dp.sv
module mcr_write_dp
  import mcr_write_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobe,
  input  logic [CTL_W-1:0] wrData,
  input  logic             code64Load,
  output logic [CTL_W-1:0] ctlReg,
  output logic             longActive,
  output logic             codeWide64,
  output logic             truncPcPulse,
  output logic             flushPulse,
  output logic             protMode,
  output logic             addSegFlag,
  output logic [FPU_N-1:0] fpuFlags
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg       <= RESET_VAL;
      longActive   <= 1'b0;
      codeWide64   <= 1'b0;
      truncPcPulse <= 1'b0;
      flushPulse   <= 1'b0;
      protMode     <= 1'b0;
      addSegFlag   <= 1'b0;
      fpuFlags     <= '0;
    end else begin
      flushPulse   <= strobe.flush;
      truncPcPulse <= strobe.exitLm;
      if (strobe.commit) begin
        ctlReg   <= wrData | FORCE_ONE;
        protMode <= wrData[PE_POS];
        fpuFlags <= wrData[MP_POS +: FPU_N];
        if (!wrData[PE_POS]) addSegFlag <= 1'b1;
      end
      if (strobe.exitLm) begin
        longActive <= 1'b0;
        codeWide64 <= 1'b0;
      end else begin
        if (strobe.enterLm) longActive <= 1'b1;
        if (code64Load && longActive) codeWide64 <= 1'b1;
      end
    end
  end

  AST_CODE64_NEEDS_LM: assert property (@(posedge clk) disable iff (!rstN)
    codeWide64 |-> longActive); // R9
  AST_ADDSEG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    addSegFlag |=> addSegFlag); // R7
  AST_TRUNC_ON_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    truncPcPulse |-> (!longActive && !codeWide64)); // R6
  AST_ET_STAYS_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[ET_POS]); // R2
endmodule

// File: rtl/mcr_write_top.sv
module mcr_write_top
  import mcr_write_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        addrExtEn,
  input  logic        lmEnable,
  input  logic        code64Load,
  output logic [31:0] ctlReg,
  output logic        longActive,
  output logic        codeWide64,
  output logic        truncPcPulse,
  output logic        flushPulse,
  output logic        protMode,
  output logic        addSegFlag,
  output logic        fpuMonitor,
  output logic        fpuEmulate,
  output logic        fpuTaskSw
);
  wrStrobe_t        strobe;
  logic [FPU_N-1:0] fpuFlags;

  mcr_write_ctrl i_ctrl (
    .wrEn      (wrEn),
    .wrData    (wrData),
    .addrExtEn (addrExtEn),
    .lmEnable  (lmEnable),
    .curReg    (ctlReg),
    .curLong   (longActive),
    .strobe    (strobe)
  );

  mcr_write_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .code64Load   (code64Load),
    .ctlReg       (ctlReg),
    .longActive   (longActive),
    .codeWide64   (codeWide64),
    .truncPcPulse (truncPcPulse),
    .flushPulse   (flushPulse),
    .protMode     (protMode),
    .addSegFlag   (addSegFlag),
    .fpuFlags     (fpuFlags)
  );

  assign fpuMonitor = fpuFlags[0];
  assign fpuEmulate = fpuFlags[1];
  assign fpuTaskSw  = fpuFlags[2];

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(ctlReg) && !flushPulse && !truncPcPulse)); // R10
  AST_DROP_NO_PAE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && lmEnable && !addrExtEn && !ctlReg[PG_POS] && wrData[PG_POS])
      |=> ($stable(ctlReg) && !longActive)); // R5
  AST_ENTER_LM: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && lmEnable && addrExtEn && !ctlReg[PG_POS] && wrData[PG_POS])
      |=> longActive); // R4
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> $past(wrEn)); // R3
endmodule

// File: tb/test_mcr_write_top.sv
module test_mcr_write_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, addrExtEn, lmEnable, code64Load;
  logic [31:0] wrData;
  logic [31:0] ctlReg;
  logic        longActive, codeWide64, truncPcPulse, flushPulse;
  logic        protMode, addSegFlag, fpuMonitor, fpuEmulate, fpuTaskSw;

  always #2 clk = ~clk;

  mcr_write_top i_mcr_write_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .addrExtEn(addrExtEn), .lmEnable(lmEnable), .code64Load(code64Load),
    .ctlReg(ctlReg), .longActive(longActive), .codeWide64(codeWide64),
    .truncPcPulse(truncPcPulse), .flushPulse(flushPulse), .protMode(protMode),
    .addSegFlag(addSegFlag), .fpuMonitor(fpuMonitor), .fpuEmulate(fpuEmulate),
    .fpuTaskSw(fpuTaskSw)
  );

  typedef struct {
    string       tag;
    logic [31:0] reg32;
    logic [8:0]  flags;
  } expItem_t;

  expItem_t    sbQueue[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  logic [31:0] mReg;
  logic        mLa, mC64, mPm, mAs;
  logic [2:0]  mFpu;

  function automatic logic [8:0] packOut();
    return {longActive, codeWide64, truncPcPulse, flushPulse,
            protMode, addSegFlag, fpuTaskSw, fpuEmulate, fpuMonitor};
  endfunction

  task automatic step(input string tag, input logic wr, input logic [31:0] d,
                      input logic pae, input logic lme, input logic c64);
    expItem_t e;
    logic fl, enter, abandon, leave;
    @(negedge clk);
    wrEn = wr; wrData = d; addrExtEn = pae; lmEnable = lme; code64Load = c64;
    fl      = wr && (((d ^ mReg) & 32'h8001_0001) != 0);
    enter   = wr && !mReg[31] && d[31] && lme;
    abandon = enter && !pae;
    leave   = wr && mReg[31] && !d[31] && mLa;
    if (leave) begin
      mLa = 1'b0; mC64 = 1'b0;
    end else if (c64 && mLa) begin
      mC64 = 1'b1;
    end
    if (wr && !abandon) begin
      mReg = d | 32'h10; mPm = d[0]; mFpu = d[3:1];
      if (!d[0]) mAs = 1'b1;
      if (enter) mLa = 1'b1;
    end
    e.tag   = tag;
    e.reg32 = mReg;
    e.flags = {mLa, mC64, leave, fl, mPm, mAs, mFpu[2], mFpu[1], mFpu[0]};
    sbQueue.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQueue.size() > 0) begin
        expItem_t e;
        e = sbQueue.pop_front();
        checks++;
        if (ctlReg !== e.reg32 || packOut() !== e.flags) begin
          errors++;
          $display("FAIL %s: actual reg=%h flags=%b expected reg=%h flags=%b",
                   e.tag, ctlReg, packOut(), e.reg32, e.flags);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; addrExtEn = 1'b0;
    lmEnable = 1'b0; code64Load = 1'b0;
    mReg = 32'h10; mLa = 0; mC64 = 0; mPm = 0; mAs = 0; mFpu = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (ctlReg !== 32'h10 || packOut() !== 9'b0) begin
      errors++;
      $display("FAIL R1 reset: actual reg=%h flags=%b expected reg=00000010 flags=0",
               ctlReg, packOut());
    end
    @(negedge clk);
    rstN = 1'b1;
    // R2 R8 R7: FPU bits, bit0 clear sets add-seg, no flush bit changed (R3)
    step("R8", 1, 32'h0000_000E, 0, 0, 0);
    // R3 R7: bit0 toggles -> flush, prot on, add-seg stays
    step("R7", 1, 32'h0000_000F, 0, 0, 0);
    // R3: only non-flush bits change -> no flush
    step("R3", 1, 32'h0000_0F0F, 0, 0, 0);
    // R3: write-protect bit toggles -> flush
    step("R3", 1, 32'h0001_0F0F, 0, 0, 0);
    // R10: idle cycles
    step("R10", 0, 32'hFFFF_FFFF, 1, 1, 0);
    step("R10", 0, 32'h0000_0000, 1, 1, 0);
    // R9: load strobe outside long mode ignored
    step("R9", 0, 32'h0, 0, 0, 1);
    // R5: paging on with enable but no extension -> dropped, flush still issued
    step("R5", 1, 32'h8001_0001, 0, 1, 0);
    // R4: same with extension -> long mode entered
    step("R4", 1, 32'h8001_0001, 1, 1, 0);
    // R9: load strobe in long mode sets flag
    step("R9", 0, 32'h0, 0, 0, 1);
    // R2: write keeping paging on, bit 4 clear in data -> forced
    step("R2", 1, 32'h8001_0003, 1, 1, 0);
    // R6: paging off in long mode -> exit and truncate pulse
    step("R6", 1, 32'h0001_0001, 0, 1, 0);
    step("R6", 0, 32'h0, 0, 0, 0);
    // R9: strobe after exit ignored
    step("R9", 0, 32'h0, 0, 0, 1);
    // R4: paging on without long-mode enable -> no long mode
    step("R4", 1, 32'h8000_0000, 1, 0, 0);
    // R6: paging off outside long mode -> no truncate pulse
    step("R6", 1, 32'h0000_0006, 0, 0, 0);
    // R3: back-to-back flush writes
    step("R3", 1, 32'h0000_0007, 0, 0, 0);
    step("R3", 1, 32'h0000_0006, 0, 0, 0);
    step("R10", 0, 32'h0, 0, 0, 0);
    step("R10", 0, 32'h0, 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule